// File: doc/BRIEF.md
# Camera Receiver Link Bring-Up Sequencer

This block is a finite-state machine that owns the bring-up and tear-down of a serial camera receiver and its physical layer. Software pulses a start request. The block then asks the image sensor to park every transmit lane in the LP-11 idle level. It issues one configuration write on the physical layer's test port and latches the number of active data lanes. It then lifts the three reset controls one at a time: PHY shutdown, PHY reset and controller reset.

After that the block reads the physical layer's lane-status word. It waits until the clock lane and every enabled data lane report stop state. Only then does it ask the sensor to start its high-speed clock. Once the sensor acknowledges, the block waits for the status word to report that a high-speed clock is being received, and then raises ready.

Either wait can end in a timeout. A timeout reports its own error code and a copy of the last status word, and sends the block back to idle. A stop request in the running state takes the link down in reverse order.

Top module: `csi_rx_bringup`

## Requirements
- R1: While reset is held and after it is released, all three reset controls, ready, every sensor request and the test write strobe are low, the error code is 0, the captured status is 0 and the lane count output is 1.
- R2: A start pulse in idle raises the LP-11 request, which stays high until the cycle after the sensor acknowledges it. No test write happens before that acknowledge.
- R3: The cycle after the LP-11 acknowledge, the test write strobe is high for exactly one cycle with address 0x44 and data 0x14. At all other times the address and data outputs are 0.
- R4: The lane count input is latched in the cycle after the test write. The value 0 is stored as 1 and values above 4 are stored as 4. PHY shutdown, PHY reset and controller reset are then released on three successive cycles, in that order.
- R5: Stop state holds when status bit 10 is set and data-lane bits 4 to 4+n-1 are all set, where n is the latched lane count. Data-lane bits for lanes above n are ignored. The clock request rises the cycle after stop state is seen.
- R6: If stop state is not seen within max(T,1) cycles, where T is the stop timeout input, the block returns to idle with error code 1 and captures the status word sampled in the last waiting cycle.
- R7: The clock request stays high until the cycle after the sensor acknowledges it. Status bit 8 (HS clock received) has no effect before that acknowledge.
- R8: After the clock acknowledge, ready rises the cycle after status bit 8 is seen, and stays high until a stop request.
- R9: If bit 8 is not seen within max(C,1) cycles of the clock wait, where C is the clock timeout input, the block returns to idle with error code 2 and the captured status word.
- R10: A stop request while running drops ready and all three reset controls in the next cycle. One cycle later the halt request rises and stays high until the cycle after the sensor acknowledges it. The block then returns to idle.
- R11: A new start clears the error code and the captured status in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start bring-up (sampled in idle) |
| stop_i | input | 1 | Stop request (sampled while running) |
| lane_cnt_i | input | 3 | Requested data lane count |
| stop_tmo_i | input | TMO_W | Stop-state wait limit in cycles |
| clk_tmo_i | input | TMO_W | Clock-active wait limit in cycles |
| phy_status_i | input | 12 | Lane-status word from the physical layer |
| sensor_lp11_req_o | output | 1 | Ask sensor to enter LP-11 |
| sensor_lp11_ack_i | input | 1 | Sensor confirms LP-11 |
| sensor_clk_req_o | output | 1 | Ask sensor to start HS clock |
| sensor_clk_ack_i | input | 1 | Sensor confirms clock started |
| sensor_halt_req_o | output | 1 | Ask sensor to stop streaming |
| sensor_halt_ack_i | input | 1 | Sensor confirms stop |
| phy_test_wr_o | output | 1 | Test-port write strobe |
| phy_test_addr_o | output | 8 | Test-port register address |
| phy_test_data_o | output | 8 | Test-port write data |
| lanes_o | output | 3 | Latched active lane count |
| phy_shutdown_n_o | output | 1 | PHY shutdown control, active low |
| phy_rst_n_o | output | 1 | PHY reset, active low |
| ctrl_rst_n_o | output | 1 | Controller reset, active low |
| ready_o | output | 1 | Link up and clock received |
| err_o | output | 2 | 0 none, 1 stop timeout, 2 clock timeout |
| err_status_o | output | 12 | Status word captured at timeout |

## Verification
A wrong sequencer state shows at the ports in the cycle that follows it. Every reset control, request strobe and ready flag decodes the state directly, so a skipped or repeated step moves the edge of one of those outputs by a cycle. A miscounted wait window shows as the error code appearing a cycle early or late. A bad lane mask shows as a clock request that appears while an enabled lane is still low, or that never appears while the enabled lanes are all stopped. The bench compares every output against a behavioural model on every cycle, so each of these faults is reported in the cycle it first appears.

// File: rtl/csi_bup_pkg.sv
package csi_bup_pkg;
  localparam int LANES_MAX     = 4;
  localparam int LC_W          = $clog2(LANES_MAX + 1);
  localparam int ST_W          = 12;
  localparam int DL_STOP_LSB   = 4;
  localparam int CLK_HS_BIT    = 8;
  localparam int CLK_STOP_BIT  = 10;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LP11, ST_PINIT, ST_LANES, ST_SHDN, ST_PRST, ST_CRST,
    ST_WSTOP, ST_CKREQ, ST_WCLK, ST_RUN, ST_HRST, ST_HSNS
  } bup_state_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_STOP_TMO = 2'd1,
    ERR_CLK_TMO  = 2'd2
  } bup_err_e;
endpackage

// File: rtl/bup_wait_timer.sv
module bup_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  localparam int CW = W + 1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  // The count restarts whenever the sequencer leaves a wait state.
  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) cnt_d = '0;
    else if (!expired_o) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // The last permitted cycle is reached when cnt+1 meets the limit.
  // A limit of 0 behaves as a one-cycle window.
  assign expired_o = (CW'(cnt_q) + CW'(1)) >= CW'(limit_i);

  // R6 R9: an expired window always ends the wait in the next cycle
  a_r6_expire_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && expired_o |=> !run_i);
endmodule

// File: rtl/bup_lane_check.sv
module bup_lane_check
  import csi_bup_pkg::*;
(
  input  logic [LANES_MAX-1:0] dl_stop_i,
  input  logic                 clk_stop_i,
  input  logic [LC_W-1:0]      lanes_i,
  output logic                 all_stop_o
);
  logic [LANES_MAX-1:0] lane_ok;

  // Lanes at or above the configured count are masked to "ok".
  for (genvar g = 0; g < LANES_MAX; g++) begin : g_lane
    assign lane_ok[g] = dl_stop_i[g] | (LC_W'(g) >= lanes_i);
  end

  assign all_stop_o = clk_stop_i & (&lane_ok);
endmodule

// File: rtl/csi_rx_bringup.sv
module csi_rx_bringup
  import csi_bup_pkg::*;
#(
  parameter int         TMO_W      = 16,
  parameter logic [7:0] PINIT_ADDR = 8'h44,
  parameter logic [7:0] PINIT_DATA = 8'h14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [LC_W-1:0]  lane_cnt_i,
  input  logic [TMO_W-1:0] stop_tmo_i,
  input  logic [TMO_W-1:0] clk_tmo_i,
  input  logic [ST_W-1:0]  phy_status_i,
  output logic             sensor_lp11_req_o,
  input  logic             sensor_lp11_ack_i,
  output logic             sensor_clk_req_o,
  input  logic             sensor_clk_ack_i,
  output logic             sensor_halt_req_o,
  input  logic             sensor_halt_ack_i,
  output logic             phy_test_wr_o,
  output logic [7:0]       phy_test_addr_o,
  output logic [7:0]       phy_test_data_o,
  output logic [LC_W-1:0]  lanes_o,
  output logic             phy_shutdown_n_o,
  output logic             phy_rst_n_o,
  output logic             ctrl_rst_n_o,
  output logic             ready_o,
  output logic [1:0]       err_o,
  output logic [ST_W-1:0]  err_status_o
);
  bup_state_e       state_q, state_d;
  logic [LC_W-1:0]  lanes_q, lanes_d;
  bup_err_e         err_q, err_d;
  logic [ST_W-1:0]  est_q, est_d;
  logic             stop_ok, hs_seen, tmo_hit, waiting;
  logic             stop_fail, clk_fail, err_en, lanes_en;
  logic [TMO_W-1:0] tmo_limit;

  // One counter serves both waits; the limit follows the state.
  assign waiting   = (state_q == ST_WSTOP) || (state_q == ST_WCLK);
  assign tmo_limit = (state_q == ST_WCLK) ? clk_tmo_i : stop_tmo_i;
  assign hs_seen   = phy_status_i[CLK_HS_BIT];

  bup_wait_timer #(.W(TMO_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (waiting),
    .limit_i   (tmo_limit),
    .expired_o (tmo_hit)
  );

  bup_lane_check u_lanes (
    .dl_stop_i  (phy_status_i[DL_STOP_LSB +: LANES_MAX]),
    .clk_stop_i (phy_status_i[CLK_STOP_BIT]),
    .lanes_i    (lanes_q),
    .all_stop_o (stop_ok)
  );

  assign stop_fail = (state_q == ST_WSTOP) && !stop_ok && tmo_hit;
  assign clk_fail  = (state_q == ST_WCLK)  && !hs_seen && tmo_hit;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_LP11;
      ST_LP11:  if (sensor_lp11_ack_i) state_d = ST_PINIT;
      ST_PINIT: state_d = ST_LANES;
      ST_LANES: state_d = ST_SHDN;
      ST_SHDN:  state_d = ST_PRST;
      ST_PRST:  state_d = ST_CRST;
      ST_CRST:  state_d = ST_WSTOP;
      ST_WSTOP: if (stop_ok) state_d = ST_CKREQ;
                else if (tmo_hit) state_d = ST_IDLE;
      ST_CKREQ: if (sensor_clk_ack_i) state_d = ST_WCLK;
      ST_WCLK:  if (hs_seen) state_d = ST_RUN;
                else if (tmo_hit) state_d = ST_IDLE;
      ST_RUN:   if (stop_i) state_d = ST_HRST;
      ST_HRST:  state_d = ST_HSNS;
      ST_HSNS:  if (sensor_halt_ack_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Lane count, clamped into 1..LANES_MAX
  assign lanes_en = (state_q == ST_LANES);
  always_comb begin
    lanes_d = lane_cnt_i;
    if (lane_cnt_i == '0) lanes_d = LC_W'(1);
    else if (lane_cnt_i > LC_W'(LANES_MAX)) lanes_d = LC_W'(LANES_MAX);
  end

  // Error capture: set on a timeout, cleared by a new start
  assign err_en = ((state_q == ST_IDLE) && start_i) || stop_fail || clk_fail;
  always_comb begin
    err_d = ERR_NONE;
    est_d = '0;
    if (stop_fail) begin
      err_d = ERR_STOP_TMO;
      est_d = phy_status_i;
    end else if (clk_fail) begin
      err_d = ERR_CLK_TMO;
      est_d = phy_status_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lanes_q <= LC_W'(1);
      err_q   <= ERR_NONE;
      est_q   <= '0;
    end else begin
      state_q <= state_d;
      if (lanes_en) lanes_q <= lanes_d;
      if (err_en) begin
        err_q <= err_d;
        est_q <= est_d;
      end
    end
  end

  // Moore output decode
  assign sensor_lp11_req_o = (state_q == ST_LP11);
  assign sensor_clk_req_o  = (state_q == ST_CKREQ);
  assign sensor_halt_req_o = (state_q == ST_HSNS);
  assign phy_test_wr_o     = (state_q == ST_PINIT);
  assign phy_test_addr_o   = phy_test_wr_o ? PINIT_ADDR : 8'h00;
  assign phy_test_data_o   = phy_test_wr_o ? PINIT_DATA : 8'h00;
  assign phy_shutdown_n_o  = (state_q >= ST_SHDN) && (state_q <= ST_RUN);
  assign phy_rst_n_o       = (state_q >= ST_PRST) && (state_q <= ST_RUN);
  assign ctrl_rst_n_o      = (state_q >= ST_CRST) && (state_q <= ST_RUN);
  assign ready_o           = (state_q == ST_RUN);
  assign lanes_o           = lanes_q;
  assign err_o             = err_q;
  assign err_status_o      = est_q;

  a_r3_write_follows_lp11_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_test_wr_o) |-> $past(sensor_lp11_ack_i));
  a_r4_phy_rst_after_shdn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_rst_n_o) |-> $past(phy_shutdown_n_o));
  a_r4_ctrl_rst_after_phy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_n_o) |-> $past(phy_rst_n_o));
  a_r5_clk_req_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sensor_clk_req_o) |-> $past(stop_ok));
  a_r8_ready_needs_hs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(hs_seen) && !sensor_clk_req_o);
  a_r10_ready_drops_with_resets: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> !ctrl_rst_n_o && !phy_rst_n_o && !phy_shutdown_n_o);
  a_r10_halt_after_teardown: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sensor_halt_req_o) |-> $past(!ready_o) && !ctrl_rst_n_o);
endmodule

// File: tb/csi_rx_bringup_bench.sv
`timescale 1ns/1ps
module csi_rx_bringup_bench;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start_i = 0, stop_i = 0, lp_ack = 0, ck_ack = 0, h_ack = 0;
  logic [2:0]    lane_cnt = 3'd2;
  logic [TW-1:0] stop_tmo = 16'd20, clk_tmo = 16'd20;
  logic [11:0]   status = 12'h000;

  logic lp_req, ck_req, h_req, t_wr, shdn_n, prst_n, crst_n, rdy;
  logic [7:0] t_addr, t_data;
  logic [2:0] lanes;
  logic [1:0] err;
  logic [11:0] est;

  csi_rx_bringup u_csi_rx_bringup (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .lane_cnt_i(lane_cnt), .stop_tmo_i(stop_tmo), .clk_tmo_i(clk_tmo),
    .phy_status_i(status),
    .sensor_lp11_req_o(lp_req), .sensor_lp11_ack_i(lp_ack),
    .sensor_clk_req_o(ck_req), .sensor_clk_ack_i(ck_ack),
    .sensor_halt_req_o(h_req), .sensor_halt_ack_i(h_ack),
    .phy_test_wr_o(t_wr), .phy_test_addr_o(t_addr), .phy_test_data_o(t_data),
    .lanes_o(lanes), .phy_shutdown_n_o(shdn_n), .phy_rst_n_o(prst_n),
    .ctrl_rst_n_o(crst_n), .ready_o(rdy), .err_o(err), .err_status_o(est)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // Behavioural reference: phase numbers follow the bring-up steps
  // 0 idle,1 lp11,2 write,3 lanes,4 shdn,5 phyrst,6 ctrlrst,7 stopwait,
  // 8 clkreq,9 clkwait,10 run,11 teardown,12 halt
  int mph = 0, mcnt = 0, mlanes = 1, merr = 0;
  logic [11:0] mest = 12'h000;

  function automatic int clampl(int v);
    if (v < 1) return 1;
    if (v > 4) return 4;
    return v;
  endfunction

  function automatic bit lanes_stopped(logic [11:0] s, int n);
    if (!s[10]) return 0;
    for (int i = 0; i < n; i++) if (!s[4+i]) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mph = 0; mcnt = 0; mlanes = 1; merr = 0; mest = 0;
    end else begin
      int lim;
      int nxt;
      nxt = mph;
      lim = (mph == 9) ? int'(clk_tmo) : int'(stop_tmo);
      if (lim < 1) lim = 1;
      case (mph)
        0: if (start_i) begin nxt = 1; merr = 0; mest = 0; end
        1: if (lp_ack) nxt = 2;
        2: nxt = 3;
        3: begin mlanes = clampl(int'(lane_cnt)); nxt = 4; end
        4: nxt = 5;
        5: nxt = 6;
        6: nxt = 7;
        7: if (lanes_stopped(status, mlanes)) nxt = 8;
           else if (mcnt + 1 >= lim) begin nxt = 0; merr = 1; mest = status; end
        8: if (ck_ack) nxt = 9;
        9: if (status[8]) nxt = 10;
           else if (mcnt + 1 >= lim) begin nxt = 0; merr = 2; mest = status; end
        10: if (stop_i) nxt = 11;
        11: nxt = 12;
        12: if (h_ack) nxt = 0;
        default: nxt = 0;
      endcase
      if (mph == 7 || mph == 9) mcnt = mcnt + 1; else mcnt = 0;
      mph = nxt;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2 lp11_req", 32'(lp_req), 32'(mph == 1));
    chk("R3 test_wr", 32'(t_wr), 32'(mph == 2));
    chk("R3 test_addr", 32'(t_addr), (mph == 2) ? 32'h44 : 32'h0);
    chk("R3 test_data", 32'(t_data), (mph == 2) ? 32'h14 : 32'h0);
    chk("R4 shutdown_n", 32'(shdn_n), 32'(mph >= 4 && mph <= 10));
    chk("R4 phy_rst_n", 32'(prst_n), 32'(mph >= 5 && mph <= 10));
    chk("R4 ctrl_rst_n", 32'(crst_n), 32'(mph >= 6 && mph <= 10));
    chk("R4 lanes", 32'(lanes), 32'(mlanes));
    chk("R7 clk_req", 32'(ck_req), 32'(mph == 8));
    chk("R8 ready", 32'(rdy), 32'(mph == 10));
    chk("R10 halt_req", 32'(h_req), 32'(mph == 12));
    chk("R6 R9 err_code", 32'(err), 32'(merr));
    chk("R6 R9 err_status", 32'(est), 32'(mest));
  endtask

  task automatic step();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic wait_ph(int p);
    for (int i = 0; i < 200 && mph != p; i++) step();
  endtask

  task automatic pulse_start();
    start_i = 1; step(); start_i = 0;
  endtask

  task automatic ack_lp11(int delay);
    repeat (delay) step();
    lp_ack = 1; step(); lp_ack = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    chk("R1 shutdown_n in reset", 32'(shdn_n), 0);
    chk("R1 ctrl_rst_n in reset", 32'(crst_n), 0);
    chk("R1 ready in reset", 32'(rdy), 0);
    chk("R1 lanes in reset", 32'(lanes), 1);
    rst_n = 1;
    step();
    chk("R1 err after reset", 32'(err), 0);
    chk("R1 lp11_req after reset", 32'(lp_req), 0);
    step();

    // Normal bring-up with two lanes; upper data lanes not stopped (R5 mask)
    lane_cnt = 3'd2; status = 12'h430;
    pulse_start();
    ack_lp11(3);
    wait_ph(8);
    chk("R5 clk_req with masked upper lanes", 32'(ck_req), 1);
    status = 12'h530;          // bit 8 before the acknowledge
    repeat (3) step();
    chk("R7 bit 8 ignored before clk ack", 32'(rdy), 0);
    chk("R7 clk_req held", 32'(ck_req), 1);
    ck_ack = 1; step(); ck_ack = 0;
    wait_ph(10);
    step();
    chk("R8 ready after HS clock", 32'(rdy), 1);

    // Tear-down
    stop_i = 1; step(); stop_i = 0;
    chk("R10 ready low after stop", 32'(rdy), 0);
    chk("R10 ctrl_rst_n low after stop", 32'(crst_n), 0);
    step();
    chk("R10 halt_req", 32'(h_req), 1);
    step(); step();
    h_ack = 1; step(); h_ack = 0;
    chk("R10 back to idle", 32'(h_req), 0);
    step();

    // Stop-state timeout: four lanes, lane 3 not stopped
    lane_cnt = 3'd4; status = 12'h470; stop_tmo = 16'd5;
    pulse_start();
    ack_lp11(0);
    wait_ph(0);
    step();
    chk("R6 stop timeout code", 32'(err), 1);
    chk("R6 captured status", 32'(est), 32'h470);
    chk("R6 resets low after timeout", 32'(shdn_n), 0);

    // Restart clears error; zero lane request; clock timeout
    lane_cnt = 3'd0; status = 12'h6F0; clk_tmo = 16'd4; stop_tmo = 16'd20;
    pulse_start();
    chk("R11 error cleared by start", 32'(err), 0);
    chk("R11 status cleared by start", 32'(est), 0);
    ack_lp11(1);
    wait_ph(8);
    ck_ack = 1; step(); ck_ack = 0;
    wait_ph(0);
    step();
    chk("R4 lane count 0 stored as 1", 32'(lanes), 1);
    chk("R9 clock timeout code", 32'(err), 2);
    chk("R9 captured status", 32'(est), 32'h6F0);

    // Lane request above four clamps; full bring-up and stop
    lane_cnt = 3'd7; status = 12'h6F0;
    pulse_start();
    ack_lp11(0);
    wait_ph(7);
    chk("R4 lane count clamped to 4", 32'(lanes), 4);
    wait_ph(8);
    ck_ack = 1; step(); ck_ack = 0;
    step();
    status = 12'h7F0;
    wait_ph(10);
    step();
    chk("R8 ready with four lanes", 32'(rdy), 1);
    stop_i = 1; step(); stop_i = 0;
    wait_ph(12);
    h_ack = 1; step(); h_ack = 0;
    step();
    chk("R10 idle after halt ack", 32'(h_req), 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule